// File: doc/BRIEF.md
# FIFO-Buffered UART Transmitter

This block is the transmit half of one asynchronous serial channel. A host pushes bytes through a write strobe. Two storage modes are available. In buffered mode the bytes queue in a 64-entry first-in first-out store. In direct mode there is a single holding slot, and a later write replaces the byte waiting there. A shifter takes one byte at a time and sends it as a character on the serial line. Each character has a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional odd or even parity bit, then one or two high stop bits.

Bit timing comes from an oversampling tick input. One bit lasts 16 ticks, or 8 ticks in the fast mode. The line format, the stop-bit count and the tick rate are taken from the control inputs when a byte enters the shifter. Two flags report the state of the transmit path: one shows that the storage is empty, and one shows that the shifter is idle. An interrupt output follows the storage-empty flag while its enable input is high.

Top module: `uart_tx_chan`

## Requirements
- R1: After reset `txd_o` is 1, `thr_empty_o` is 1 and `tsr_empty_o` is 1. The line stays at 1 whenever no character is being sent.
- R2: A character starts with one bit at 0. The data bits follow, least significant bit first. The number of data bits is 5 + `len_sel_i` (code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8).
- R3: When `par_en_i` is 1, one parity bit follows the data bits. It is the XOR of the data bits sent (even parity) when `par_odd_i` is 0, and the inverse of that XOR (odd parity) when `par_odd_i` is 1.
- R4: The character ends with one stop bit at 1, or with two stop bits at 1 when `two_stop_i` is 1.
- R5: Every bit lasts 16 ticks of `tick_i`. When `os8_i` is 1 at load time, every bit lasts 8 ticks.
- R6: With `fifo_en_i` at 1, up to 64 written bytes are kept and sent in write order. A write made while 64 bytes are held is dropped.
- R7: With `fifo_en_i` at 0, only one byte is held. A write while that byte is still waiting replaces it.
- R8: `thr_empty_o` goes to 1 on the tick at which the last waiting byte moves into the shifter. In buffered mode it is 1 exactly when the store is empty.
- R9: `tsr_empty_o` is 0 from the tick that loads a byte until the tick that ends the last stop bit. It then returns to 1 if no byte is waiting.
- R10: If a byte is waiting when a stop bit ends, the next start bit begins on that same tick, so no idle bit time falls between the two characters.
- R11: `irq_o` is 1 exactly when `thr_empty_o` is 1 and `irq_en_i` is 1.
- R12: A change of `fifo_en_i` discards every waiting byte, and a write in the cycle of the change is dropped. A character already in the shifter is still sent in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, one cycle wide |
| fifo_en_i | input | 1 | 1 selects the 64-entry store, 0 selects the single slot |
| irq_en_i | input | 1 | Enables the transmit-empty interrupt |
| wr_en_i | input | 1 | Write strobe for one byte |
| wr_data_i | input | 8 | Byte to send |
| len_sel_i | input | 2 | Data bit count minus 5 |
| par_en_i | input | 1 | Adds a parity bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop_i | input | 1 | 1 selects two stop bits |
| os8_i | input | 1 | 1 selects 8 ticks per bit |
| txd_o | output | 1 | Serial line output |
| thr_empty_o | output | 1 | No byte waiting to be sent |
| tsr_empty_o | output | 1 | Shifter idle |
| irq_o | output | 1 | Transmit-empty interrupt |

## Verification
The assertions check the cycle-level rules on every cycle. The line level is held for each shifter phase, the store never overflows, and a full store ignores a write. The single-slot mode never holds more than one byte. The bit counter stays in range for the selected rate. A load or a mode change has the expected effect on the two flags one cycle later. Some results can only come from the bench, which decodes the line at the middle of each bit. These are the bit order, parity values and stop-bit counts for random formats, the exact bit length, the lack of a gap between queued characters, and the bytes that are dropped or replaced.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W = 8;
    localparam int LEN_W  = 2;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
    } line_cfg_t;

    // Number of data bits still to be sent after the first one: len code 0 means 5 bits
    function automatic logic [CNT_W-1:0] bits_after_first(input logic [LEN_W-1:0] len);
        return CNT_W'(4) + CNT_W'(len);
    endfunction

    function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                       input logic [LEN_W-1:0]  len,
                                       input logic              odd);
        logic [DATA_W-1:0] keep;
        keep = {DATA_W{1'b1}} >> (LEN_W'(3) - len);
        return (^(d & keep)) ^ odd;
    endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          single_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_en_i,
    output logic [DW-1:0] rd_data_o,
    output logic          empty_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic          do_pop, do_push, do_replace;

    always_comb begin
        st_d       = st_q;
        do_pop     = rd_en_i && (st_q.cnt != '0);
        do_replace = single_i && wr_en_i && (st_q.cnt != '0) && !do_pop;
        if (single_i)
            do_push = wr_en_i && ((st_q.cnt == '0) || do_pop);
        else
            do_push = wr_en_i && (st_q.cnt != FULL_CNT);
        mem_we   = (do_push || do_replace) && !flush_i;
        mem_addr = do_replace ? st_q.rp : st_q.wp;

        if (flush_i) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) st_d.wp = st_q.wp + AW'(1);
            if (do_pop)  st_d.rp = st_q.rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= wr_data_i;
    end

    assign rd_data_o = mem[st_q.rp];
    assign empty_o   = (st_q.cnt == '0);

    // R6: occupancy never exceeds the depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    // R6: a write into a full store without a read leaves it full and unchanged
    a_r6_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_i && !flush_i && wr_en_i && !rd_en_i && st_q.cnt == FULL_CNT)
        |=> (st_q.cnt == FULL_CNT && $stable(st_q.wp)));

    // R7: single-slot mode holds one byte at most
    a_r7_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (single_i && !flush_i) |-> (st_q.cnt <= CW'(1)));

endmodule

// File: rtl/utx_bitclk.sv
module utx_bitclk #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic os8_i,
    input  logic restart_i,
    input  logic run_i,
    output logic bit_end_o
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST_FULL = CW'(OSR - 1);
    localparam logic [CW-1:0] LAST_HALF = CW'(OSR / 2 - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          half;
    } bclk_st_t;

    bclk_st_t st_d, st_q;
    logic [CW-1:0] last;

    always_comb begin
        st_d      = st_q;
        last      = st_q.half ? LAST_HALF : LAST_FULL;
        bit_end_o = run_i && tick_i && (st_q.cnt == last);
        if (restart_i) begin
            st_d.cnt  = '0;
            st_d.half = os8_i;
        end else if (run_i && tick_i) begin
            st_d.cnt = bit_end_o ? '0 : st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: in the 8-tick mode the count never passes the shorter bit
    a_r5_half_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.half |-> (st_q.cnt <= LAST_HALF));

    // R5: the count moves only on a tick or a restart
    a_r5_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              have_data_i,
    input  logic [DATA_W-1:0] din_i,
    input  line_cfg_t         cfg_i,
    input  logic              bit_end_i,
    output logic              load_o,
    output logic              busy_o,
    output logic              txd_o
);
    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  nleft;
        logic              par_en;
        logic              par_bit;
        logic              stop2;
        logic              txd;
    } shf_st_t;

    localparam shf_st_t RESET_ST = '{state: ST_IDLE, sh: '0, nleft: '0,
                                     par_en: 1'b0, par_bit: 1'b0, stop2: 1'b0, txd: 1'b1};

    shf_st_t st_d, st_q;
    logic    last_stop_end;

    assign last_stop_end = (st_q.state == ST_STOP) && bit_end_i && !st_q.stop2;
    assign load_o = tick_i && have_data_i && ((st_q.state == ST_IDLE) || last_stop_end);

    always_comb begin
        st_d = st_q;
        if (load_o) begin
            st_d.state   = ST_START;
            st_d.txd     = 1'b0;
            st_d.sh      = din_i;
            st_d.nleft   = bits_after_first(cfg_i.len);
            st_d.par_en  = cfg_i.par_en;
            st_d.par_bit = parity_of(din_i, cfg_i.len, cfg_i.par_odd);
            st_d.stop2   = cfg_i.two_stop;
        end else if (bit_end_i) begin
            case (st_q.state)
                ST_START: begin
                    st_d.state = ST_DATA;
                    st_d.txd   = st_q.sh[0];
                    st_d.sh    = {1'b0, st_q.sh[DATA_W-1:1]};
                end
                ST_DATA: begin
                    if (st_q.nleft != '0) begin
                        st_d.txd   = st_q.sh[0];
                        st_d.sh    = {1'b0, st_q.sh[DATA_W-1:1]};
                        st_d.nleft = st_q.nleft - CNT_W'(1);
                    end else if (st_q.par_en) begin
                        st_d.state = ST_PAR;
                        st_d.txd   = st_q.par_bit;
                    end else begin
                        st_d.state = ST_STOP;
                        st_d.txd   = 1'b1;
                    end
                end
                ST_PAR: begin
                    st_d.state = ST_STOP;
                    st_d.txd   = 1'b1;
                end
                ST_STOP: begin
                    if (st_q.stop2) begin
                        st_d.stop2 = 1'b0;
                    end else begin
                        st_d.state = ST_IDLE;
                        st_d.txd   = 1'b1;
                    end
                end
                default: begin
                    st_d.state = ST_IDLE;
                    st_d.txd   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.state != ST_IDLE);
    assign txd_o  = st_q.txd;

    // R1: the line rests high whenever the shifter is idle
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_IDLE) |-> st_q.txd);

    // R2: the start phase drives the line low
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_START) |-> !st_q.txd);

    // R4: every stop phase drives the line high
    a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_STOP) |-> st_q.txd);

    // R10: a waiting byte follows the final stop bit directly
    a_r10_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (last_stop_end && tick_i && have_data_i) |=> (st_q.state == ST_START));

endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int OSR   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              fifo_en_i,
    input  logic              irq_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [LEN_W-1:0]  len_sel_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              two_stop_i,
    input  logic              os8_i,
    output logic              txd_o,
    output logic              thr_empty_o,
    output logic              tsr_empty_o,
    output logic              irq_o
);
    typedef struct packed {
        logic fifo_en;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic              flush;
    logic              load;
    logic              busy;
    logic              bit_end;
    logic              buf_empty;
    logic [DATA_W-1:0] buf_data;
    line_cfg_t         cfg;

    always_comb begin
        st_d         = st_q;
        st_d.fifo_en = fifo_en_i;
        flush        = (fifo_en_i != st_q.fifo_en);
        cfg          = '{len: len_sel_i, par_en: par_en_i, par_odd: par_odd_i, two_stop: two_stop_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    utx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .single_i  (!fifo_en_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (load),
        .rd_data_o (buf_data),
        .empty_o   (buf_empty)
    );

    utx_bitclk #(.OSR(OSR)) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .os8_i     (os8_i),
        .restart_i (load),
        .run_i     (busy),
        .bit_end_o (bit_end)
    );

    utx_shifter u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .have_data_i (!buf_empty),
        .din_i       (buf_data),
        .cfg_i       (cfg),
        .bit_end_i   (bit_end),
        .load_o      (load),
        .busy_o      (busy),
        .txd_o       (txd_o)
    );

    assign thr_empty_o = buf_empty;
    assign tsr_empty_o = !busy;
    assign irq_o       = buf_empty && irq_en_i;

    // R8: in single-slot mode a load with no new write leaves the slot empty
    a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !fifo_en_i && !wr_en_i && !flush) |=> thr_empty_o);

    // R9: the shifter reports busy right after a load
    a_r9_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !tsr_empty_o);

    // R12: a mode change leaves nothing waiting
    a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> thr_empty_o);

    // R11: the interrupt never fires while it is disabled
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);

endmodule

// File: tb/sim_uart_tx_chan.sv
module sim_uart_tx_chan;
    localparam int TDIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       tick_on = 1'b0;
    int         div = 0;
    logic       fifo_en = 1'b0, irq_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] len = 2'd3;
    logic       pe = 1'b0, po = 1'b0, two = 1'b0, os8 = 1'b0;
    logic       txd, thr_empty, tsr_empty, irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (!tick_on) begin
            tick <= 1'b0;
            div  <= 0;
        end else begin
            tick <= (div == 0);
            div  <= (div == TDIV - 1) ? 0 : div + 1;
        end
    end

    uart_tx_chan u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .fifo_en_i(fifo_en), .irq_en_i(irq_en),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .len_sel_i(len), .par_en_i(pe),
        .par_odd_i(po), .two_stop_i(two), .os8_i(os8), .txd_o(txd),
        .thr_empty_o(thr_empty), .tsr_empty_o(tsr_empty), .irq_o(irq)
    );

    function automatic logic [7:0] mask_of(input logic [1:0] l);
        return 8'hFF >> (2'd3 - l);
    endfunction

    function automatic logic exp_parity(input logic [7:0] b, input logic [1:0] l, input logic odd);
        return (^(b & mask_of(l))) ^ odd;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (tick) c++;
        end
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_data = b;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Decodes one character at mid-bit and compares it with the expected format
    task automatic check_frame(input logic [7:0] b, input bit chained, input bit flags, input string req);
        int         n;
        int         t;
        bit         ok;
        logic [7:0] got;
        logic [7:0] exp;
        n = os8 ? 8 : 16;
        ok = 1'b1;
        got = 8'h00;
        if (!chained) begin
            t = 0;
            while (txd !== 1'b0 && t < 30000) begin
                @(negedge clk);
                t++;
            end
            if (t >= 30000) ok = 1'b0;
            if (flags) begin
                chk(thr_empty == 1'b1, "R8 holding empty once the byte is loaded", thr_empty, 1);
                chk(tsr_empty == 1'b0, "R9 shifter busy at start bit", tsr_empty, 0);
            end
            wait_ticks(n / 2);
        end else begin
            wait_ticks(n);
        end
        if (txd !== 1'b0) ok = 1'b0;
        for (int i = 0; i < 5 + int'(len); i++) begin
            wait_ticks(n);
            got[i] = txd;
        end
        if (pe) begin
            wait_ticks(n);
            if (txd !== exp_parity(b, len, po)) ok = 1'b0;
        end
        wait_ticks(n);
        if (txd !== 1'b1) ok = 1'b0;
        if (two) begin
            wait_ticks(n);
            if (txd !== 1'b1) ok = 1'b0;
        end
        if (flags) chk(tsr_empty == 1'b0, "R9 shifter busy during stop bit", tsr_empty, 0);
        exp = b & mask_of(len);
        chk(ok && got == exp, req, got, exp);
    endtask

    // From mid stop bit: line must stay high and both flags report empty
    task automatic check_quiet(input int nbits, input string req);
        int  n;
        bit  ok;
        n  = os8 ? 8 : 16;
        ok = 1'b1;
        wait_ticks(n / 2);
        chk(tsr_empty == 1'b1 && thr_empty == 1'b1, {req, " flags empty after last stop"},
            {tsr_empty, thr_empty}, 3);
        for (int k = 0; k < nbits; k++) begin
            wait_ticks(n);
            if (txd !== 1'b1) ok = 1'b0;
        end
        chk(ok, {req, " line idle, nothing more sent"}, ok, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] q [70];
        logic [7:0] b;
        void'($urandom(32'h5EED_0042));
        tick_on = 1'b1;
        repeat (4) @(negedge clk);

        // R1 / R11: reset state
        chk(txd == 1'b1, "R1 line high in reset", txd, 1);
        chk(thr_empty == 1'b1 && tsr_empty == 1'b1, "R1 flags empty in reset", {thr_empty, tsr_empty}, 3);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1 && tsr_empty == 1'b1, "R1 idle after reset", {txd, tsr_empty}, 3);
        chk(irq == 1'b0, "R11 irq off while disabled", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R11 irq on when empty and enabled", irq, 1);

        // Directed single-slot 8N1 frame with flag checks (R2, R8, R9, R11)
        write_byte(8'hA5);
        chk(thr_empty == 1'b0, "R8 holding full after write", thr_empty, 0);
        chk(irq == 1'b0, "R11 irq off while a byte waits", irq, 0);
        check_frame(8'hA5, 1'b0, 1'b1, "R2 8N1 frame A5");
        check_quiet(2, "R9");

        // Random formats, rates and modes (R2 R3 R4 R5)
        for (int r = 0; r < 24; r++) begin
            len     = 2'($urandom_range(0, 3));
            pe      = 1'($urandom_range(0, 1));
            po      = 1'($urandom_range(0, 1));
            two     = 1'($urandom_range(0, 1));
            os8     = 1'($urandom_range(0, 1));
            fifo_en = 1'($urandom_range(0, 1));
            @(negedge clk);
            b = 8'($urandom);
            write_byte(b);
            check_frame(b, 1'b0, 1'b1, "R2/R3/R4/R5 random format frame");
            wait_ticks(os8 ? 4 : 8);
            chk(tsr_empty == 1'b1, "R9 shifter idle after stop", tsr_empty, 1);
        end

        // Buffered mode: 70 writes while stalled, 64 kept and sent back to back (R6 R10)
        len = 2'd3; pe = 1'b0; two = 1'b0; os8 = 1'b0;
        tick_on = 1'b0;
        fifo_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < 70; k++) begin
            q[k] = 8'($urandom);
            write_byte(q[k]);
        end
        chk(thr_empty == 1'b0 && irq == 1'b0, "R8 store not empty after fill", {thr_empty, irq}, 0);
        tick_on = 1'b1;
        check_frame(q[0], 1'b0, 1'b0, "R6 first queued byte");
        for (int k = 1; k < 64; k++)
            check_frame(q[k], 1'b1, 1'b0, "R10 R6 back-to-back queued byte");
        check_quiet(3, "R6 dropped writes");

        // Mode change during a character: current one finishes, waiting one discarded (R12)
        write_byte(8'h5A);
        write_byte(8'hC3);
        fork
            check_frame(8'h5A, 1'b0, 1'b0, "R12 character in shifter completes");
            begin
                while (txd !== 1'b0) @(negedge clk);
                @(negedge clk);
                fifo_en = 1'b0;
            end
        join
        check_quiet(3, "R12 waiting byte discarded");

        // Single slot: a second write replaces the waiting byte (R7)
        tick_on = 1'b0;
        @(negedge clk);
        write_byte(8'h11);
        write_byte(8'h3C);
        tick_on = 1'b1;
        check_frame(8'h3C, 1'b0, 1'b0, "R7 replaced byte sent");
        check_quiet(3, "R7 only one character");

        // Mode change while idle discards stored bytes (R12)
        tick_on = 1'b0;
        fifo_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        write_byte(8'h01);
        write_byte(8'h02);
        write_byte(8'h03);
        chk(thr_empty == 1'b0, "R12 store holds bytes before change", thr_empty, 0);
        fifo_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(thr_empty == 1'b1 && irq == 1'b1, "R12 change empties store", {thr_empty, irq}, 3);
        tick_on = 1'b1;
        wait_ticks(40);
        chk(txd == 1'b1 && tsr_empty == 1'b1, "R12 nothing sent after change", {txd, tsr_empty}, 3);

        irq_en = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R11 irq off after disable", irq, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule